// File: doc/BRIEF.md
# Strobe-Handshaked FIFO with Occupancy Flags

This block is a first-in first-out buffer of 64 five-bit words. The writing side and the reading side each use a strobe with a ready handshake. The writer raises `shift_in` while `in_rdy` is high, and the word on `din` is stored. The reader raises `shift_out` while `out_rdy` is high, and the word shown on `dout` is removed.

Both strobes are treated as asynchronous. Each passes through a two-flop synchroniser on the system clock, and only its rising edge acts. After every accepted transfer, the matching ready output drops for one clock. This lets a chained neighbour see each transfer as a separate pulse on the ready line.

A word counter drives two occupancy flags:
- A half-full flag.
- A flag that marks either end of the range, near full or near empty.

The data outputs carry an active-low enable and float when it is not asserted. A synchronous active-low master reset empties the buffer. The master reset must be applied after power-up.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, the buffer is emptied. After the reset, `in_rdy`=1, `out_rdy`=0, `half_full`=0 and `edge_zone`=1.
- R2: When a rising edge of `shift_in` is acted on while `in_rdy` is high, `din` is stored. `in_rdy` then reads 0 for exactly one clock, and afterwards reads 1 unless the buffer holds 64 words.
- R3: A `shift_in` rising edge that is acted on while `in_rdy` is low, including when the buffer is full, stores nothing.
- R4: Words leave in the order they were stored. While `out_rdy` is high and `out_en_n` is low, `dout` shows the oldest stored word.
- R5: When a rising edge of `shift_out` is acted on while `out_rdy` is high, the oldest word is removed. `out_rdy` then reads 0 for exactly one clock, and afterwards reads 1 if words remain.
- R6: A `shift_out` rising edge that is acted on while `out_rdy` is low removes nothing.
- R7: `half_full` is 1 exactly when 32 or more words are stored.
- R8: `edge_zone` is 1 exactly when 56 or more words, or 8 or fewer words, are stored.
- R9: While `out_en_n` is high, `dout` is released to high impedance. While it is low, `dout` drives the head word.
- R10: When a write and a read are acted on in the same clock, the word count does not change and the order of the data is kept.
- R11: Suppose a strobe rises between two clock edges. The transfer is then acted on at the third rising clock edge after that point, and its ready output reads 0 after that edge. A strobe held high moves only one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| shift_in | input | 1 | Write strobe, asynchronous, acts on its rising edge |
| din | input | 5 | Word to store |
| in_rdy | output | 1 | High when a word can be accepted |
| shift_out | input | 1 | Read strobe, asynchronous, acts on its rising edge |
| out_en_n | input | 1 | Active-low enable for `dout` |
| dout | output | 5 | Head word, or high impedance when disabled |
| out_rdy | output | 1 | High when `dout` holds a valid word |
| half_full | output | 1 | 32 or more words stored |
| edge_zone | output | 1 | 56 or more, or 8 or fewer, words stored |

## Verification
The main function is exercised with several input patterns, and each one separates a different class of fault:
- **Directed single transfers**, with a check on every clock, pin down the synchroniser latency and the one-clock ready drop.
- **A strobe held high for many clocks** separates level sensing from edge detection.
- **A complete fill followed by a rejected write, then a complete drain,** tests the flag thresholds at 8/9, 31/32 and 55/56 in both directions. It also shows whether a write to a full buffer corrupts the data.
- **Paired write-and-read strobes, and a seeded random walk** (first biased toward writes, then toward reads), catch errors in the count and in pointer wrap. They also catch errors from toggling the output enable mid-stream.

// File: rtl/strobe_fifo_pkg.sv
// Package: shared types for the strobe-handshaked FIFO.
// Assumes: nothing beyond the standard language.
package strobe_fifo_pkg;

    // Occupancy flags decoded from the word count.
    typedef struct packed {
        logic half;      // at or above the midpoint
        logic edge_zone; // near full or near empty
    } occ_flags_t;

endpackage

// File: rtl/strobe_edge.sv
// Module: strobe_edge
// Synchronises an asynchronous strobe through STAGES flops. It then gives
// a one-clock pulse when the synchronised level goes from 0 to 1.
// Assumes: the strobe stays at each level for at least two clocks.
module strobe_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);

    // chain[STAGES-1] is the synchronised level; chain[STAGES] is its prior value
    logic [STAGES:0] chain;

    // Shift the strobe through the synchroniser and the history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], strobe};
        end
    end

    // Rising edge when the previous sample is 0 and the current one is 1
    assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/fifo_store.sv
// Module: fifo_store
// Word storage with a write pointer and a read pointer. It shows the word
// at the read pointer at all times.
// Assumes: the caller never writes when full or reads when empty.
module fifo_store #(
    parameter int WIDTH = 5,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] head
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam bit POW2 = ((1 << AW) == DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [AW-1:0]    wr_ptr_nx;
    logic [AW-1:0]    rd_ptr_nx;

    // Pointer advance: natural wrap for power-of-two depths, compare otherwise
    generate
        if (POW2) begin : g_wrap_free
            assign wr_ptr_nx = wr_ptr + 1'b1;
            assign rd_ptr_nx = rd_ptr + 1'b1;
        end else begin : g_wrap_cmp
            assign wr_ptr_nx = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            assign rd_ptr_nx = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Store the incoming word at the write pointer
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Advance the pointers on each accepted transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr_nx;
            if (rd_en) rd_ptr <= rd_ptr_nx;
        end
    end

    // The oldest stored word
    assign head = mem[rd_ptr];

endmodule

// File: rtl/fifo_level.sv
// Module: fifo_level
// Keeps the stored-word count and decodes the occupancy flags from it.
// Assumes: wr_en is never high at full and rd_en is never high at empty.
module fifo_level
    import strobe_fifo_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int HALF_MARK = DEPTH / 2,
    parameter int LOW_MARK  = DEPTH / 8,
    parameter int HIGH_MARK = DEPTH - DEPTH / 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       has_space,
    output logic                       has_data,
    output occ_flags_t                 flags
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C = CW'(HALF_MARK);
    localparam logic [CW-1:0] LOW_C  = CW'(LOW_MARK);
    localparam logic [CW-1:0] HIGH_C = CW'(HIGH_MARK);

    // Count up on a lone write, down on a lone read, hold on both or neither
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (wr_en && !rd_en) begin
            level <= level + 1'b1;
        end else if (rd_en && !wr_en) begin
            level <= level - 1'b1;
        end
    end

    // Decode space, data and threshold flags from the count
    always_comb begin
        has_space       = (level != FULL_C);
        has_data        = (level != '0);
        flags.half      = (level >= HALF_C);
        flags.edge_zone = (level >= HIGH_C) || (level <= LOW_C);
    end

endmodule

// File: rtl/strobe_fifo.sv
// Module: strobe_fifo (top)
// FIFO with strobe-and-ready handshakes on both sides and occupancy flags.
// Each ready output drops for one clock after every accepted transfer.
// Assumes: strobes may be asynchronous to clk; rst_n is synchronous.
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int WIDTH     = 5,
    parameter int DEPTH     = 64,
    parameter int SYNC      = 2,
    parameter int HALF_MARK = DEPTH / 2,
    parameter int LOW_MARK  = DEPTH / 8,
    parameter int HIGH_MARK = DEPTH - DEPTH / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] din,
    output logic             in_rdy,
    input  logic             shift_out,
    input  logic             out_en_n,
    output logic [WIDTH-1:0] dout,
    output logic             out_rdy,
    output logic             half_full,
    output logic             edge_zone
);

    localparam int CW = $clog2(DEPTH + 1);

    logic             in_rise;
    logic             out_rise;
    logic             wr_go;
    logic             rd_go;
    logic             in_rdy_q;
    logic             out_rdy_q;
    logic             has_space;
    logic             has_data;
    logic [CW-1:0]    level;
    logic [WIDTH-1:0] head;
    occ_flags_t       flags;

    strobe_edge #(.STAGES(SYNC)) u_in_edge (
        .clk(clk), .rst_n(rst_n), .strobe(shift_in), .rise(in_rise)
    );

    strobe_edge #(.STAGES(SYNC)) u_out_edge (
        .clk(clk), .rst_n(rst_n), .strobe(shift_out), .rise(out_rise)
    );

    // Transfers happen only on a detected edge while the side is ready
    assign wr_go = in_rise  && in_rdy_q;
    assign rd_go = out_rise && out_rdy_q;

    fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_go), .wr_data(din),
        .rd_en(rd_go), .head(head)
    );

    fifo_level #(
        .DEPTH(DEPTH), .HALF_MARK(HALF_MARK),
        .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)
    ) u_level (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_go), .rd_en(rd_go),
        .level(level), .has_space(has_space),
        .has_data(has_data), .flags(flags)
    );

    // Input ready: drop for one clock per write, then follow free space
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_rdy_q <= 1'b1;
        end else if (wr_go) begin
            in_rdy_q <= 1'b0;
        end else begin
            in_rdy_q <= has_space;
        end
    end

    // Output ready: drop for one clock per read, then follow stored data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_rdy_q <= 1'b0;
        end else if (rd_go) begin
            out_rdy_q <= 1'b0;
        end else begin
            out_rdy_q <= has_data;
        end
    end

    assign in_rdy    = in_rdy_q;
    assign out_rdy   = out_rdy_q;
    assign half_full = flags.half;
    assign edge_zone = flags.edge_zone;

    // Per-bit output drivers that float when the enable is not asserted
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_drv
            assign dout[b] = out_en_n ? 1'bz : head[b];
        end
    endgenerate

endmodule

// File: rtl/strobe_fifo_chk.sv
// Module: strobe_fifo_chk
// Property checker for strobe_fifo, attached to it by the bind below.
// Assumes: connected to the top's internal transfer and count signals.
module strobe_fifo_chk #(
    parameter int DEPTH     = 64,
    parameter int HALF_MARK = DEPTH / 2,
    parameter int LOW_MARK  = DEPTH / 8,
    parameter int HIGH_MARK = DEPTH - DEPTH / 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_go,
    input logic                       rd_go,
    input logic                       in_rdy,
    input logic                       out_rdy,
    input logic                       half_full,
    input logic                       edge_zone,
    input logic [$clog2(DEPTH+1)-1:0] level
);

    localparam int CW = $clog2(DEPTH + 1);

    // R2: an accepted write pulls input-ready low on the next clock
    p_in_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> !in_rdy);

    // R5: an accepted read pulls output-ready low on the next clock
    p_out_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> !out_rdy);

    // R3: input-ready is never high with the buffer full
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_rdy |-> (level < CW'(DEPTH)));

    // R6: output-ready is never high with the buffer empty
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_rdy |-> (level != '0));

    // R10: a paired write and read leave the count unchanged
    p_pair_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && rd_go) |=> (level == $past(level)));

    // R10: the count moves by at most one per clock
    p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((level == $past(level)) ||
                          (level == $past(level) + 1'b1) ||
                          (level + 1'b1 == $past(level))));

    // R7: half-full rises only on reaching the midpoint
    p_half_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_full) |-> (level == CW'(HALF_MARK)));

    // R8: the edge-zone flag clears only just inside either threshold
    p_zone_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(edge_zone) |-> ((level == CW'(LOW_MARK + 1)) ||
                              (level == CW'(HIGH_MARK - 1))));

endmodule

bind strobe_fifo strobe_fifo_chk #(
    .DEPTH(DEPTH), .HALF_MARK(HALF_MARK),
    .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .rd_go(rd_go),
    .in_rdy(in_rdy), .out_rdy(out_rdy), .half_full(half_full),
    .edge_zone(edge_zone), .level(level)
);

// File: tb/strobe_fifo_test.sv
module strobe_fifo_test;

    localparam int T = 10;
    localparam int W = 5;
    localparam int D = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_in = 1'b0;
    logic [W-1:0] din = '0;
    logic         in_rdy;
    logic         shift_out = 1'b0;
    logic         out_en_n = 1'b0;
    logic [W-1:0] dout;
    logic         out_rdy;
    logic         half_full;
    logic         edge_zone;

    int checks = 0;
    int fails = 0;
    logic [W-1:0] model [$];

    strobe_fifo uut (
        .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .din(din),
        .in_rdy(in_rdy), .shift_out(shift_out), .out_en_n(out_en_n),
        .dout(dout), .out_rdy(out_rdy), .half_full(half_full),
        .edge_zone(edge_zone)
    );

    always #(T/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_half(input int n);
        return n >= 32;
    endfunction

    function automatic bit exp_zone(input int n);
        return (n >= 56) || (n <= 8);
    endfunction

    // Flags and readies against the model count (sampled at a falling edge)
    task automatic check_state();
        int n = model.size();
        chk(half_full == exp_half(n), "R7", "half_full", half_full, exp_half(n));
        chk(edge_zone == exp_zone(n), "R8", "edge_zone", edge_zone, exp_zone(n));
        chk(in_rdy == (n != D), "R2", "in_rdy", in_rdy, n != D);
        chk(out_rdy == (n != 0), "R5", "out_rdy", out_rdy, n != 0);
    endtask

    function automatic bit released();
        return $isunknown(dout) || (dout == '0);
    endfunction

    // One strobe cycle on either or both sides, with the model updated
    task automatic xfer(input bit do_w, input bit do_r, input logic [W-1:0] d);
        bit w_ok;
        bit r_ok;
        @(negedge clk);
        w_ok = do_w && in_rdy;
        r_ok = do_r && out_rdy;
        if (model.size() != 0 && out_rdy) begin
            if (!out_en_n) chk(dout == model[0], "R4", "dout head", dout, model[0]);
            else           chk(released(), "R9", "dout released", dout, 0);
        end
        shift_in = do_w; shift_out = do_r; din = d;
        repeat (3) @(negedge clk);
        shift_in = 1'b0; shift_out = 1'b0;
        if (w_ok) model.push_back(d);
        if (r_ok) void'(model.pop_front());
        repeat (3) @(negedge clk);
    endtask

    task automatic drain();
        while (model.size() != 0) xfer(1'b0, 1'b1, '0);
        check_state();
    endtask

    initial begin : watchdog
        #(T * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(in_rdy == 1'b1, "R1", "in_rdy after reset", in_rdy, 1);
        chk(out_rdy == 1'b0, "R1", "out_rdy after reset", out_rdy, 0);
        chk(half_full == 1'b0, "R1", "half_full after reset", half_full, 0);
        chk(edge_zone == 1'b1, "R1", "edge_zone after reset", edge_zone, 1);

        // R11 and R2: timing of a single write, checked on every clock
        shift_in = 1'b1; din = 5'h15;
        @(negedge clk); chk(in_rdy == 1'b1, "R11", "in_rdy edge1", in_rdy, 1);
        @(negedge clk); chk(in_rdy == 1'b1, "R11", "in_rdy edge2", in_rdy, 1);
        @(negedge clk); chk(in_rdy == 1'b0, "R11", "in_rdy edge3", in_rdy, 0);
        shift_in = 1'b0;
        @(negedge clk); chk(in_rdy == 1'b1, "R2", "in_rdy edge4", in_rdy, 1);
        chk(out_rdy == 1'b1, "R4", "out_rdy after write", out_rdy, 1);
        model.push_back(5'h15);
        repeat (2) @(negedge clk);

        // R9: output enable
        out_en_n = 1'b1; #1;
        chk(released(), "R9", "dout disabled", dout, 0);
        out_en_n = 1'b0; #1;
        chk(dout == 5'h15, "R9", "dout enabled", dout, 5'h15);

        // R5: timing of a read with a word left behind
        xfer(1'b1, 1'b0, 5'h0A);
        @(negedge clk);
        shift_out = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_rdy == 1'b1, "R5", "out_rdy edge2", out_rdy, 1);
        @(negedge clk); chk(out_rdy == 1'b0, "R5", "out_rdy edge3", out_rdy, 0);
        shift_out = 1'b0;
        @(negedge clk); chk(out_rdy == 1'b1, "R5", "out_rdy edge4", out_rdy, 1);
        void'(model.pop_front());
        chk(dout == 5'h0A, "R4", "next head", dout, 5'h0A);
        repeat (2) @(negedge clk);
        drain();

        // R6: read strobe on an empty buffer does nothing
        @(negedge clk);
        shift_out = 1'b1;
        repeat (3) @(negedge clk);
        shift_out = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_rdy == 1'b0, "R6", "out_rdy stays low", out_rdy, 0);
        chk(edge_zone == 1'b1, "R6", "edge_zone still empty", edge_zone, 1);
        xfer(1'b1, 1'b0, 5'h07);
        chk(dout == 5'h07, "R6", "first word after empty read", dout, 5'h07);
        drain();

        // R11: a strobe held high stores only one word
        @(negedge clk);
        shift_in = 1'b1; din = 5'h03;
        repeat (20) @(negedge clk);
        shift_in = 1'b0;
        repeat (3) @(negedge clk);
        model.push_back(5'h03);
        xfer(1'b0, 1'b1, '0);
        chk(out_rdy == 1'b0, "R11", "only one word held", out_rdy, 0);
        drain();

        // Fill to full, checking flags at every count (R7, R8)
        for (int i = 0; i < D; i++) begin
            xfer(1'b1, 1'b0, W'(i * 7 + 1));
            check_state();
        end
        // R3: write to a full buffer is ignored
        xfer(1'b1, 1'b0, 5'h1F);
        chk(in_rdy == 1'b0, "R3", "in_rdy full", in_rdy, 0);
        chk(model.size() == D, "R3", "model count", model.size(), D);
        while (model.size() != 0) begin
            xfer(1'b0, 1'b1, '0);
            check_state();
        end

        // R10: paired write and read
        for (int i = 0; i < 10; i++) xfer(1'b1, 1'b0, W'(i + 2));
        for (int i = 0; i < 6; i++) begin
            xfer(1'b1, 1'b1, W'(i + 20));
            chk(model.size() == 10, "R10", "count held", model.size(), 10);
            check_state();
        end
        drain();

        // Random walk: biased up, then biased down, with enable toggles
        for (int i = 0; i < 400; i++) begin
            int r = $urandom % 10;
            int up = (i < 200) ? 6 : 3;
            logic [W-1:0] v = W'($urandom);
            if (r == 9) begin
                @(negedge clk);
                out_en_n = ~out_en_n;
            end else if (r < up) xfer(1'b1, 1'b0, v);
            else if (r < 7)      xfer(1'b0, 1'b1, v);
            else                 xfer(1'b1, 1'b1, v);
            check_state();
        end
        @(negedge clk);
        out_en_n = 1'b0;
        drain();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule